// File: doc/BRIEF.md
# Reset Control and Cause Register

This block is a 16-bit control and status register that sits beside a device's reset and power logic. A single-cycle write strobe with a 16-bit data word updates it, and the current value is always visible on a read-data bus. Three control fields drive outputs: a byte-order select for the external port, a level-held CPU reset, and a global hard-reset request that a software write starts.

Five status flags record why the device last reset or woke: power-on or pin reset, software hard reset, watchdog reset, wake from standby and wake from suspend. Separate input strobes report the watchdog and the two wake events. Each flag keeps its value through the reset and sleep classes that do not concern it, and only firmware clears it, by writing 0 to the flag's bit. A power-on reset (the block's synchronous `rst`) is the only event that wipes the other cause flags.

Top module: `rst_ctrl_cause`

## Requirements
- R1: While and after `rst` is high, `bus_rdata` reads 16'h0C01, `big_endian` is 0, `cpu_rst_n` is 1 and `hard_rst_req` is 0.
- R2: Bit 15 is read/write; a write sets it and `big_endian` follows it from the cycle after the write (0 little endian, 1 big endian).
- R3: Bit 10 is an active-low CPU reset; writing 0 drives `cpu_rst_n` low and it stays low, with no self-clearing, until a write of 1.
- R4: A write with bit 11 equal to 0 raises `hard_rst_req` in the next cycle for exactly HRST_CYCLES cycles (8 by default); bit 11 always reads 1.
- R5: That software hard-reset write sets flag bit 1, returns bit 15 to 0 and bit 10 to 1, and leaves flag bits 0, 2, 3 and 4 unchanged even if the same write holds 0 in them.
- R6: While `hard_rst_req` is high, bus writes are ignored.
- R7: Strobe `ev_wake_susp` sets flag bit 4, `ev_wake_stby` sets flag bit 3 and `ev_wdt_rst` sets flag bit 2, from the next cycle; setting one flag leaves every other flag unchanged.
- R8: A watchdog strobe also returns bits 15 and 10 to 0 and 1, and a bus write in the same cycle is ignored.
- R9: Outside a hard reset, writing 0 to a flag bit (bits 4..0) clears it and writing 1 leaves it as it was.
- R10: When a set strobe and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R11: `rst` clears flag bits 1..4 and sets flag bit 0; no strobe or software hard reset clears any flag.
- R12: Bits 14..12 and 9..5 always read 0 and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on / pin reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current register value |
| ev_wdt_rst | input | 1 | Strobe: watchdog-induced hard reset occurred |
| ev_wake_stby | input | 1 | Strobe: wake from standby |
| ev_wake_susp | input | 1 | Strobe: wake from suspend |
| big_endian | output | 1 | Port byte order, 1 = big endian |
| cpu_rst_n | output | 1 | Active-low CPU reset, level held |
| hard_rst_req | output | 1 | Global hard-reset request pulse |

## Verification
Every flag and control bit is visible on `bus_rdata` or on an output one cycle after the edge that changed it, so a wrong internal value shows up at the very next sample; the bench compares the whole read word and all three outputs against an arithmetic model every cycle. A pulse counter that is off by one shows as a `hard_rst_req` pulse that is one cycle long or short, and as writes accepted one cycle too early. Sweeps over all 32 clear patterns and all event combinations expose wrong priority or cross-talk between flags in the cycle after the offending write.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int REG_W    = 16;
  localparam int NFLAG    = 5;
  localparam int B_ORDER  = 15;
  localparam int B_HRST   = 11;
  localparam int B_CPU    = 10;
  localparam int F_POR    = 0;
  localparam int F_SWR    = 1;
  localparam int F_WDT    = 2;
  localparam int F_STBY   = 3;
  localparam int F_SUSP   = 4;
  localparam logic [NFLAG-1:0] FLAG_RST = 5'b00001;
endpackage

// File: rtl/rcc_flags.sv
module rcc_flags #(
  parameter int NF = 5,
  parameter logic [NF-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= RST_VAL[i];
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

  // R1 / R11: reset leaves the power-on pattern
  a_r11_reset_pattern: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> flags == RST_VAL);
  // R7 / R10: a set wins over everything
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));
  // R9: a clear without a set lands
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));
  // R11: no set and no clear keeps every flag
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (set == '0 && clr == '0) |=> $stable(flags));
endmodule

// File: rtl/rcc_hrst_pulse.sv
module rcc_hrst_pulse #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic req
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      req <= 1'b1;
      cnt <= LOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      req <= 1'b0;
    end
  end

  // checker: consecutive high cycles of req
  logic [CW-1:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst)      hi_len <= '0;
    else if (req) hi_len <= hi_len + 1'b1;
    else          hi_len <= '0;
  end

  // R4: pulse lasts exactly LEN cycles
  a_r4_pulse_len: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> hi_len == CW'(LEN));
  // R4: start while idle always raises the request
  a_r4_start_raises: assert property (@(posedge clk) disable iff (rst)
    start |=> req);
endmodule

// File: rtl/rst_ctrl_cause.sv
module rst_ctrl_cause
  import rcc_pkg::*;
#(
  parameter int HRST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              ev_wdt_rst,
  input  logic              ev_wake_stby,
  input  logic              ev_wake_susp,
  output logic              big_endian,
  output logic              cpu_rst_n,
  output logic              hard_rst_req
);
  logic             wr_ok;
  logic             sw_hrst;
  logic             ctl_reset;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flags;
  logic             unused_wbits;

  assign unused_wbits = ^{bus_wdata[14:12], bus_wdata[9:5]};

  // writes are dropped during a hard-reset pulse or a watchdog reset
  assign wr_ok     = bus_wr && !hard_rst_req && !ev_wdt_rst;
  assign sw_hrst   = wr_ok && !bus_wdata[B_HRST];
  assign ctl_reset = sw_hrst || ev_wdt_rst;

  always_comb begin
    flag_set         = '0;
    flag_set[F_SWR]  = sw_hrst;
    flag_set[F_WDT]  = ev_wdt_rst;
    flag_set[F_STBY] = ev_wake_stby;
    flag_set[F_SUSP] = ev_wake_susp;
    flag_clr         = (wr_ok && !sw_hrst) ? ~bus_wdata[NFLAG-1:0] : '0;
  end

  rcc_flags #(.NF(NFLAG), .RST_VAL(FLAG_RST)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flags)
  );

  rcc_hrst_pulse #(.LEN(HRST_CYCLES)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .start (sw_hrst),
    .req   (hard_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst || ctl_reset) begin
      big_endian <= 1'b0;
      cpu_rst_n  <= 1'b1;
    end else if (wr_ok) begin
      big_endian <= bus_wdata[B_ORDER];
      cpu_rst_n  <= bus_wdata[B_CPU];
    end
  end

  always_comb begin
    bus_rdata              = '0;
    bus_rdata[B_ORDER]     = big_endian;
    bus_rdata[B_HRST]      = 1'b1;
    bus_rdata[B_CPU]       = cpu_rst_n;
    bus_rdata[NFLAG-1:0]   = flags;
  end

  // R3: CPU reset is held by level
  a_r3_cpu_level: assert property (@(posedge clk) disable iff (rst)
    (!wr_ok && !ctl_reset) |=> $stable(cpu_rst_n));
  // R5: a software hard reset sets its flag and restores control
  a_r5_swr_effect: assert property (@(posedge clk) disable iff (rst)
    $rose(hard_rst_req) |-> (flags[F_SWR] && !big_endian && cpu_rst_n));
  // R6: writes during the pulse change nothing
  a_r6_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (hard_rst_req && !ev_wdt_rst) |=> ($stable(big_endian) && $stable(cpu_rst_n)));
  // R8: watchdog restores control bits
  a_r8_wdt_ctl: assert property (@(posedge clk) disable iff (rst)
    ev_wdt_rst |=> (!big_endian && cpu_rst_n && flags[F_WDT]));
endmodule

// File: tb/tb_rst_ctrl_cause.sv
module tb_rst_ctrl_cause;
  localparam int HR = 8;

  logic        clk = 1'b0;
  logic        rst, bus_wr, ev_wdt_rst, ev_wake_stby, ev_wake_susp;
  logic [15:0] bus_wdata, bus_rdata;
  logic        big_endian, cpu_rst_n, hard_rst_req;

  always #2 clk = ~clk; // 250 MHz

  rst_ctrl_cause #(.HRST_CYCLES(HR)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ev_wdt_rst(ev_wdt_rst), .ev_wake_stby(ev_wake_stby),
    .ev_wake_susp(ev_wake_susp), .big_endian(big_endian), .cpu_rst_n(cpu_rst_n),
    .hard_rst_req(hard_rst_req)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  // model state
  logic       m_be, m_cpu, m_req;
  logic [4:0] m_fl;
  int         m_cnt;

  function automatic logic [15:0] m_word();
    return {m_be, 3'b000, 1'b1, m_cpu, 5'b00000, m_fl};
  endfunction

  task automatic model_edge(input logic r, w, input logic [15:0] d,
                            input logic wd, st, su);
    logic ok, hr;
    logic [4:0] s, c;
    if (r) begin
      m_be = 0; m_cpu = 1; m_fl = 5'b00001; m_req = 0; m_cnt = 0;
      return;
    end
    ok = w && !m_req && !wd;
    hr = ok && !d[11];
    s  = {su, st, wd, hr, 1'b0};
    c  = (ok && !hr) ? ~d[4:0] : 5'b0;
    m_fl = (m_fl & ~c) | s;
    if (wd || hr) begin m_be = 0; m_cpu = 1; end
    else if (ok)  begin m_be = d[15]; m_cpu = d[10]; end
    if (hr) begin m_req = 1; m_cnt = HR - 1; end
    else if (m_cnt != 0) m_cnt--;
    else m_req = 0;
  endtask

  task automatic step(input logic r, w, input logic [15:0] d,
                      input logic wd, st, su, input string tag);
    rst = r; bus_wr = w; bus_wdata = d;
    ev_wdt_rst = wd; ev_wake_stby = st; ev_wake_susp = su;
    @(posedge clk);
    model_edge(r, w, d, wd, st, su);
    @(negedge clk);
    checks++;
    if (bus_rdata !== m_word() || big_endian !== m_be ||
        cpu_rst_n !== m_cpu || hard_rst_req !== m_req) begin
      errors++;
      $display("FAIL %s: rdata=%h be=%b cpu=%b req=%b expected rdata=%h be=%b cpu=%b req=%b",
               tag, bus_rdata, big_endian, cpu_rst_n, hard_rst_req,
               m_word(), m_be, m_cpu, m_req);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 16'h0, 0, 0, 0, tag);
  endtask

  // set flags 1..4 from a fresh reset
  task automatic fill_flags(input string tag);
    step(1, 0, 16'h0, 0, 0, 0, {tag, " R1"});
    step(0, 0, 16'h0, 1, 1, 1, {tag, " R7"});
    step(0, 1, 16'h0000, 0, 0, 0, {tag, " R4"});
    idle(HR, {tag, " R4"});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_wr = 0; bus_wdata = 0;
    ev_wdt_rst = 0; ev_wake_stby = 0; ev_wake_susp = 0;
    m_be = 0; m_cpu = 1; m_fl = 5'b00001; m_req = 0; m_cnt = 0;
    @(negedge clk);
    // R1: reset state
    step(1, 0, 16'h0, 0, 0, 0, "R1 reset");
    step(1, 1, 16'hFFFF, 1, 1, 1, "R1 reset wins");
    idle(2, "R1 after reset");

    // R12: unused bits ignore writes and read 0
    step(0, 1, 16'h7FFF, 0, 0, 0, "R12 unused ones");
    step(0, 1, 16'h0C01 | 16'h73E0, 0, 0, 0, "R12 unused mix");

    // R2 / R3: sweep byte order and CPU reset
    for (int be = 0; be < 2; be++)
      for (int cp = 0; cp < 2; cp++) begin
        step(0, 1, {be[0], 4'b0001, cp[0], 10'h01F}, 0, 0, 0, "R2 R3 write");
        idle(4, "R3 level held");
      end
    step(0, 1, 16'h081F, 0, 0, 0, "R3 cpu reset asserted");
    idle(6, "R3 no self-clear");
    step(0, 1, 16'h0C1F, 0, 0, 0, "R3 cpu released");

    // R7: individual events
    step(0, 0, 16'h0, 0, 0, 1, "R7 suspend");
    step(0, 0, 16'h0, 0, 1, 0, "R7 standby");
    step(0, 1, 16'h8C1F, 0, 0, 0, "R2 set be before wdt");
    step(0, 0, 16'h0, 1, 0, 0, "R7 R8 watchdog");

    // R9: every clear pattern
    for (int p = 0; p < 32; p++) begin
      fill_flags("R9 prep");
      step(0, 1, {11'b00001000000, p[4:0]}, 0, 0, 0, "R9 clear pattern");
    end

    // R10: events against a clear-all write
    for (int e = 0; e < 8; e++) begin
      fill_flags("R10 prep");
      step(0, 1, 16'h0C00, e[2], e[1], e[0], "R10 set beats clear");
      idle(1, "R10 hold");
    end

    // R4 / R5 / R6: software hard reset
    fill_flags("R5 prep");
    step(0, 1, 16'h8A1F, 0, 0, 0, "R5 be=1 cpu=0");
    step(0, 1, 16'h8000, 0, 0, 0, "R4 R5 sw hard reset");
    for (int i = 0; i < HR + 2; i++)
      step(0, 1, 16'h8C00, 0, i[0], 0, "R4 R6 pulse window");
    step(0, 1, 16'h0C00, 0, 0, 0, "R6 write accepted after pulse");
    step(0, 1, 16'h0000, 0, 0, 0, "R4 second hard reset");
    idle(HR + 1, "R4 second pulse");

    // R8: watchdog with write in same cycle
    step(0, 1, 16'h8800, 0, 0, 0, "R8 prep");
    step(0, 1, 16'h8800, 1, 0, 0, "R8 write ignored");
    idle(1, "R8 hold");

    // R11: events do not clear; reset does
    fill_flags("R11 prep");
    step(0, 0, 16'h0, 0, 1, 0, "R11 standby keeps others");
    step(0, 0, 16'h0, 0, 0, 1, "R11 suspend keeps others");
    step(1, 0, 16'h0, 0, 0, 0, "R11 por clears");
    idle(2, "R11 after por");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule